// File: doc/BRIEF.md
# Half-Step Clock Divider

This block derives a slower clock from a source clock. An 8-bit setting chooses the ratio. Its upper seven bits hold an integer part and its lowest bit adds half a source cycle to the ratio. The block produces the divided clock and a one-cycle tick that marks the start of each output period. Logic in the source domain can use the tick as a clock enable in place of the divided clock.

The divider uses only the rising edge of the source clock. When the half step is set, it alternates a short period and a long period, one source cycle apart. This makes the average ratio exact. A setting of zero turns the divider into a pass-through: the output then follows the source clock. Settings are sampled only in the last cycle of an output period, so a change never cuts a period short.

Top module: `halfstep_clk_div`

## Requirements
- R1: While rst_ni is low, clk_o and tick_o are both low.
- R2: div_cfg_i[7:1] is the integer part D and div_cfg_i[0] is the half-step flag H. The average ratio is (D+1) + H/2 source cycles per output period.
- R3: With H = 0 and a non-zero setting, every output period lasts D+1 source cycles. For example, a setting of 6 gives a tick every 4 cycles.
- R4: With H = 1, output periods alternate between D+1 and D+2 cycles. The first period after a setting change, or after reset, is the D+1 one.
- R5: Within a period of L cycles, clk_o is high for the first ceil(L/2) cycles and low for the rest.
- R6: tick_o is high for exactly the first source cycle of every output period, the same cycle in which clk_o rises.
- R7: With a setting of 0, clk_o equals clk_i and tick_o stays high.
- R8: The setting is sampled only at the rising edge that ends a period. Changes made during a period have no effect on that period's length.
- R9: At the first rising edge after reset is released, the block samples the setting and starts a period. tick_o is high in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_cfg_i | input | 8 | Ratio setting: integer part in [7:1], half-step flag in [0] |
| clk_o | output | 1 | Divided clock |
| tick_o | output | 1 | One-cycle pulse at each period start |

## Verification
Fixed integer settings (6, and others) are held long enough to count ticks over a whole number of periods. This separates a correct integer count from an off-by-one in either direction. Half-step settings (1, 3, 13, 255) are counted over whole short/long pairs, which shows whether the alternation makes the average exact, including at the largest ratio. A zero setting shows the pass-through path, and a change made mid-period shows whether the running period keeps its old length. Random settings, changed at random moments with a fixed seed, are compared cycle by cycle against a period model. This covers pass-through entry and exit, back-to-back changes and resets in the middle of a period.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;
  typedef enum logic [1:0] {
    HD_PASS  = 2'd0,
    HD_WHOLE = 2'd1,
    HD_HALF  = 2'd2
  } hd_mode_e;
endpackage

// File: rtl/hdiv_cfg_latch.sv
module hdiv_cfg_latch #(
  parameter int unsigned INT_W = 7,
  localparam int unsigned CFG_W = INT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             bnd_i,
  output logic [CFG_W-1:0] act_cfg_o,
  output logic             alt_o,
  output logic             run_o
);
  logic [CFG_W-1:0] act_q;
  logic             alt_q;
  logic             run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      alt_q <= 1'b0;
      run_q <= 1'b0;
    end else if (bnd_i) begin
      act_q <= cfg_i;
      // Restart on the short period when the setting changes.
      alt_q <= run_q && (cfg_i == act_q) && !alt_q;
      run_q <= 1'b1;
    end
  end

  assign act_cfg_o = act_q;
  assign alt_o     = alt_q;
  assign run_o     = run_q;
endmodule

// File: rtl/hdiv_len_calc.sv
module hdiv_len_calc
  import hdiv_pkg::*;
#(
  parameter int unsigned INT_W = 7,
  localparam int unsigned CFG_W = INT_W + 1,
  localparam int unsigned CNT_W = INT_W + 1
) (
  input  logic [CFG_W-1:0] act_cfg_i,
  input  logic             alt_i,
  output hd_mode_e         mode_o,
  output logic [CNT_W-1:0] per_len_o,
  output logic [CNT_W-1:0] hi_len_o
);
  logic [INT_W-1:0] int_part;
  logic             half;
  logic [CNT_W:0]   hi_sum;

  assign int_part  = act_cfg_i[CFG_W-1:1];
  assign half      = act_cfg_i[0];
  assign per_len_o = {1'b0, int_part} + CNT_W'(1) + CNT_W'(half & alt_i);
  assign hi_sum    = {1'b0, per_len_o} + (CNT_W+1)'(1);
  assign hi_len_o  = hi_sum[CNT_W:1];

  always_comb begin
    if (act_cfg_i == '0) mode_o = HD_PASS;
    else if (half)       mode_o = HD_HALF;
    else                 mode_o = HD_WHOLE;
  end
endmodule

// File: rtl/hdiv_period_cnt.sv
module hdiv_period_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] per_len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             bnd_o
);
  logic [CNT_W-1:0] cnt_q;

  assign bnd_o = !run_i || (cnt_q == per_len_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (bnd_o) cnt_q <= '0;
    else            cnt_q <= cnt_q + CNT_W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/hdiv_out_stage.sv
module hdiv_out_stage
  import hdiv_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             bnd_i,
  input  hd_mode_e         mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] hi_len_i,
  output logic             div_lvl_o,
  output logic             clk_o,
  output logic             tick_o
);
  logic           div_q;
  logic           tick_q;
  logic [CNT_W:0] cnt_nx;

  assign cnt_nx = {1'b0, cnt_i} + (CNT_W+1)'(1);

  // Output levels are registered so clk_o never carries decode glitches.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      div_q  <= bnd_i ? 1'b1 : (cnt_nx < {1'b0, hi_len_i});
      tick_q <= bnd_i;
    end
  end

  assign div_lvl_o = div_q;
  assign tick_o    = tick_q;
  assign clk_o     = (mode_i == HD_PASS) ? (clk_i & run_i) : div_q;
endmodule

// File: rtl/halfstep_clk_div.sv
module halfstep_clk_div
  import hdiv_pkg::*;
#(
  parameter int unsigned INT_W = 7,
  localparam int unsigned CFG_W = INT_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] div_cfg_i,
  output logic             clk_o,
  output logic             tick_o
);
  localparam int unsigned CNT_W = INT_W + 1;

  logic [CFG_W-1:0] act_cfg;
  logic             alt;
  logic             run;
  logic             bnd;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] per_len;
  logic [CNT_W-1:0] hi_len;
  logic             div_lvl;
  hd_mode_e         mode;

  hdiv_cfg_latch #(.INT_W(INT_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cfg_i    (div_cfg_i),
    .bnd_i    (bnd),
    .act_cfg_o(act_cfg),
    .alt_o    (alt),
    .run_o    (run)
  );

  hdiv_len_calc #(.INT_W(INT_W)) u_len (
    .act_cfg_i(act_cfg),
    .alt_i    (alt),
    .mode_o   (mode),
    .per_len_o(per_len),
    .hi_len_o (hi_len)
  );

  hdiv_period_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .per_len_i(per_len),
    .cnt_o    (cnt),
    .bnd_o    (bnd)
  );

  hdiv_out_stage #(.CNT_W(CNT_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run),
    .bnd_i    (bnd),
    .mode_i   (mode),
    .cnt_i    (cnt),
    .hi_len_i (hi_len),
    .div_lvl_o(div_lvl),
    .clk_o    (clk_o),
    .tick_o   (tick_o)
  );
endmodule

// File: rtl/hdiv_checker.sv
module hdiv_checker #(
  parameter int unsigned INT_W = 7,
  localparam int unsigned CFG_W = INT_W + 1,
  localparam int unsigned CNT_W = INT_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CFG_W-1:0] cfg_i,
  input logic [CFG_W-1:0] act_cfg,
  input logic             alt,
  input logic             run,
  input logic             bnd,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per_len,
  input logic             div_lvl,
  input logic             clk_o,
  input logic             tick_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!tick_o && !clk_o && !div_lvl);
    end
  end

  a_r8_cfg_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd |=> $stable(act_cfg));

  a_r3_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run |-> (cnt < per_len));

  a_r4_alt_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bnd && run && cfg_i == act_cfg) |=> (alt != $past(alt)));

  a_r4_alt_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bnd && (!run || cfg_i != act_cfg)) |=> !alt);

  a_r6_tick_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && cnt == '0) |-> tick_o);

  a_r6_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && per_len > CNT_W'(1)) |=> !tick_o);

  a_r5_tick_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && act_cfg != '0) |-> div_lvl);
endmodule

bind halfstep_clk_div hdiv_checker #(.INT_W(INT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cfg_i  (div_cfg_i),
  .act_cfg(act_cfg),
  .alt    (alt),
  .run    (run),
  .bnd    (bnd),
  .cnt    (cnt),
  .per_len(per_len),
  .div_lvl(div_lvl),
  .clk_o  (clk_o),
  .tick_o (tick_o)
);

// File: tb/halfstep_clk_div_tb_top.sv
module halfstep_clk_div_tb_top;
  logic       clk;
  logic       rst_n;
  logic [7:0] cfg;
  logic       clk_div;
  logic       tick;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  // Period model state
  bit       e_run = 0;
  bit [7:0] e_cfg = 0;
  bit       e_alt = 0;
  int       e_pos = 0;

  halfstep_clk_div dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .div_cfg_i(cfg),
    .clk_o    (clk_div),
    .tick_o   (tick)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  function automatic int exp_len(bit [7:0] c, bit a);
    return int'(c[7:1]) + 1 + ((c[0] && a) ? 1 : 0);
  endfunction

  function automatic int exp_hi(int l);
    return (l + 1) / 2;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    bit bnd;
    if (!rst_n) begin
      e_run = 0; e_cfg = 0; e_alt = 0; e_pos = 0;
    end else begin
      bnd = !e_run || (e_pos == exp_len(e_cfg, e_alt) - 1);
      if (bnd) begin
        e_alt = e_run && (cfg == e_cfg) && !e_alt;
        e_cfg = cfg;
        e_run = 1;
        e_pos = 0;
      end else begin
        e_pos++;
      end
    end
  endtask

  task automatic step(output bit tk);
    bit exp_c;
    bit exp_t;
    @(posedge clk);
    model_edge();
    #2;
    if (!e_run) begin
      chk("R1 clk", clk_div, 1'b0);
      chk("R1 tick", tick, 1'b0);
    end else if (e_cfg == 0) begin
      chk("R7 clk high", clk_div, 1'b1);
      chk("R7 tick", tick, 1'b1);
    end else begin
      exp_c = e_pos < exp_hi(exp_len(e_cfg, e_alt));
      exp_t = (e_pos == 0);
      chk("R5 clk", clk_div, exp_c);
      chk("R6 tick", tick, exp_t);
    end
    tk = tick;
    #4;
    if (!e_run)          chk("R1 clk low phase", clk_div, 1'b0);
    else if (e_cfg == 0) chk("R7 clk low", clk_div, 1'b0);
    else                 chk("R5 clk low phase", clk_div, exp_c);
  endtask

  task automatic next_tick(output int n);
    bit t;
    n = 0;
    do begin
      step(t);
      n++;
    end while (!t && n < 1000);
  endtask

  task automatic count_ticks(string tag, bit [7:0] c, int window, int exp);
    int  n;
    int  cnt;
    bit  t;
    cfg = c;
    next_tick(n);
    cnt = 1;
    for (int i = 1; i < window; i++) begin
      step(t);
      if (t) cnt++;
    end
    chk_int(tag, cnt, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    bit t;
    int n;
    int g;
    void'($urandom(32'h1d5e_ed01));
    rst_n = 1'b0;
    cfg   = 8'd6;
    // R1: held in reset
    for (int i = 0; i < 4; i++) step(t);
    // R9: first edge after release starts a period
    rst_n = 1'b1;
    step(t);
    chk("R9 first tick", t, 1'b1);
    // R3 / R2: setting 6 divides by 4
    next_tick(n);
    chk_int("R3 gap for setting 6", n, 4);
    count_ticks("R3 ticks setting 6", 8'd6, 40, 10);
    // R4 / R2: half steps
    count_ticks("R4 ticks setting 3", 8'd3, 40, 16);
    count_ticks("R4 ticks setting 13", 8'd13, 45, 6);
    count_ticks("R4 ticks setting 1", 8'd1, 30, 20);
    count_ticks("R2 ticks setting 255", 8'd255, 257, 2);
    // R4: first period after change is the short one (setting 13 -> 7 then 8)
    cfg = 8'd13;
    next_tick(n);
    next_tick(n);
    chk_int("R4 short period first", n, 7);
    next_tick(n);
    chk_int("R4 long period second", n, 8);
    // R7: pass-through
    count_ticks("R7 ticks setting 0", 8'd0, 10, 10);
    // R8: mid-period change does not shorten the running period
    cfg = 8'd20;
    next_tick(n);
    next_tick(n);
    chk_int("R8 gap setting 20", n, 11);
    step(t);
    step(t);
    cfg = 8'd6;
    next_tick(n);
    chk_int("R8 old period kept", n + 2, 11);
    next_tick(n);
    chk_int("R8 new period applied", n, 4);
    // Random settings, changes and resets
    for (int i = 0; i < 6000; i++) begin
      step(t);
      g = $urandom_range(0, 99);
      if (g < 8)       cfg = 8'($urandom_range(0, 15));
      else if (g < 9)  cfg = 8'($urandom_range(0, 255));
      if (g == 99)     rst_n = 1'b0;
      else if (!rst_n) rst_n = 1'b1;
    end
    rst_n = 1'b1;
    step(t);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule